// File: doc/BRIEF.md
# Self-ID Sequence Checker

After a serial-bus reset, every node on the bus sends one or more self-identification packets. This block watches the stream of received quadlets and checks it as it arrives. Each packet is made of pairs: a data quadlet followed by a check quadlet that must be its exact bitwise inverse. The block checks that the pairs stay in phase and that the inverses are correct. It also checks that node IDs rise in the expected order, that the node ID does not change inside a multi-quadlet packet, and that the last packet of the phase reports every connected port as a child.

A failure is sorted into one of seven non-zero 3-bit codes. Only the first failure after a clear is kept. A sticky flag is set at the same clock edge. Software clears both the flag and the code by writing a 1, and the flag drives an interrupt through an enable input. A bus-reset input restarts the sequence tracking but leaves the captured error in place for software to read.

Top module: `sid_seq_checker`

## Requirements
- R1: After reset, `err_code` is 000, and `err_flag` and `irq` are 0.
- R2: When a check quadlet whose bits 31:30 are not 10 differs from the bitwise inverse of the data quadlet before it, code 111 is reported.
- R3: A phase error is reported as code 011 in four cases: a data-slot quadlet whose bits 31:30 are not 10; a check-slot quadlet whose bits 31:30 are 10; `q_eop` on a data-slot quadlet; or `phase_end` while a check quadlet is still owed.
- R4: The expected node ID is 0 after a bus reset. The node ID is in bits 29:24 of the first data quadlet of a packet. An ID below the expected one gives code 010. An ID at or above the expected one sets the expected ID to that ID plus 1.
- R5: One skip of exactly one ID is tolerated without error. A skip of two or more IDs, when no earlier skip exists, gives code 101. Any skip after an earlier skip gives code 100.
- R6: A later data quadlet in the same packet whose node ID differs from the packet's first one gives code 110.
- R7: On `phase_end`, the port fields of the last ended packet are checked. Port k is in bits 7-2k:6-2k, for k = 0 to 2. Value 11 (child) and value 00 (not connected) pass. Value 10 (parent) or 01 gives code 001.
- R8: An error is visible on `err_code` and `err_flag` after the clock edge that samples the offending input. While the flag is set, later errors leave the code unchanged.
- R9: A cycle with `clr_wr`=1 and `clr_data`=1 clears the flag and the code to 000. With `clr_data`=0 the write has no effect. An error arriving in the clearing cycle is latched.
- R10: `irq` is 1 exactly when `err_flag` and `irq_en` are both 1.
- R11: `bus_reset` returns the pairing to the data slot, clears the expected ID and clears the skip history. It ignores any quadlet in the same cycle and keeps `err_code` and `err_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_reset | input | 1 | Serial-bus reset seen; restarts sequence tracking |
| q_valid | input | 1 | Received quadlet strobe |
| q_data | input | 32 | Received quadlet |
| q_eop | input | 1 | Quadlet is the last of its packet |
| phase_end | input | 1 | Self-ID phase has finished |
| clr_wr | input | 1 | Software write to the error flag |
| clr_data | input | 1 | Write data; 1 clears flag and code |
| irq_en | input | 1 | Interrupt enable |
| err_code | output | 3 | First error code, 000 when none |
| err_flag | output | 1 | Sticky error flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the ID-skip rules, which are the easiest to get wrong. It sends one tolerated single skip followed by a second skip, and it sends a lone wide skip. A design that miscounts skips flags the legal stream or reports 101 where 100 belongs. It places a data-looking quadlet in a check slot and ends a phase with a check pending; a checker that only compares inverses reports 111 or nothing for these. It also issues a clear in the same cycle as a new error, which a latch that gives the clear priority would lose. Finally, it issues a bus reset halfway through a pair, which must re-align the pairing without erasing the captured code.

// File: rtl/sidchk_pkg.sv
package sidchk_pkg;

    typedef enum logic [2:0] {
        E_NONE   = 3'b000,
        E_PORTS  = 3'b001,
        E_IDMIS  = 3'b010,
        E_PHASE  = 3'b011,
        E_GAPS   = 3'b100,
        E_BIGGAP = 3'b101,
        E_INPKT  = 3'b110,
        E_INV    = 3'b111
    } err_code_e;

    typedef enum logic {
        SLOT_DATA = 1'b0,
        SLOT_CHK  = 1'b1
    } slot_e;

    typedef struct packed {
        logic      hit;
        err_code_e code;
    } err_rep_t;

    localparam logic [1:0] SID_TAG = 2'b10;

    // a connected port that is not a child
    function automatic logic port_not_child(input logic [1:0] f);
        return (f == 2'b01) || (f == 2'b10);
    endfunction

    function automatic err_rep_t mk_rep(input err_code_e c);
        err_rep_t r;
        r.hit  = 1'b1;
        r.code = c;
        return r;
    endfunction

endpackage

// File: rtl/sid_pair_track.sv
module sid_pair_track
    import sidchk_pkg::*;
#(
    parameter int QW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_reset,
    input  logic          q_valid,
    input  logic [QW-1:0] q_data,
    input  logic          q_eop,
    input  logic          phase_end,
    output logic          dat_stb,
    output logic          pkt_end,
    output err_rep_t      rep
);
    slot_e         slot;
    logic [QW-1:0] saved;
    logic          take;

    assign take = q_valid && !bus_reset;

    always_comb begin
        dat_stb = 1'b0;
        pkt_end = take && q_eop;
        rep     = '0;
        if (take) begin
            if (slot == SLOT_DATA) begin
                if (q_eop || (q_data[QW-1 -: 2] != SID_TAG)) rep = mk_rep(E_PHASE);
                else                                          dat_stb = 1'b1;
            end else begin
                if (q_data[QW-1 -: 2] == SID_TAG) rep = mk_rep(E_PHASE);
                else if (q_data != ~saved)        rep = mk_rep(E_INV);
            end
        end else if (!bus_reset && phase_end && slot == SLOT_CHK) begin
            rep = mk_rep(E_PHASE);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || bus_reset) begin
            slot  <= SLOT_DATA;
            saved <= '0;
        end else if (take) begin
            if (slot == SLOT_CHK) begin
                slot <= SLOT_DATA;
            end else if (dat_stb) begin
                slot  <= SLOT_CHK;
                saved <= q_data;
            end
        end
    end

    // R11: a bus reset always leaves the pairing in the data slot
    a_r11_slot_realign: assert property (@(posedge clk) disable iff (rst)
        bus_reset |=> slot == SLOT_DATA);

    // R3: an accepted check quadlet returns the pairing to the data slot
    a_r3_check_returns: assert property (@(posedge clk) disable iff (rst)
        (take && slot == SLOT_CHK) |=> slot == SLOT_DATA);

endmodule

// File: rtl/sid_id_order.sv
module sid_id_order
    import sidchk_pkg::*;
#(
    parameter int ID_W  = 6,
    parameter int NPORT = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_reset,
    input  logic               dat_stb,
    input  logic [ID_W-1:0]    id_in,
    input  logic [2*NPORT-1:0] ports_in,
    input  logic               pkt_end,
    input  logic               phase_end,
    output err_rep_t           rep
);
    localparam int PW = 2 * NPORT;

    logic [ID_W-1:0] exp_id;
    logic [ID_W-1:0] pkt_id;
    logic [ID_W-1:0] skip;
    logic [PW-1:0]   pkt_ports;
    logic [PW-1:0]   last_ports;
    logic            last_valid;
    logic            in_pkt;
    logic            gap_seen;
    logic [NPORT-1:0] bad_vec;

    assign skip = id_in - exp_id;

    for (genvar k = 0; k < NPORT; k++) begin : g_port
        assign bad_vec[k] = port_not_child(last_ports[PW-1-2*k -: 2]);
    end

    always_comb begin
        rep = '0;
        if (dat_stb) begin
            if (in_pkt) begin
                if (id_in != pkt_id) rep = mk_rep(E_INPKT);
            end else if (id_in < exp_id) begin
                rep = mk_rep(E_IDMIS);
            end else if (id_in > exp_id) begin
                if (gap_seen)       rep = mk_rep(E_GAPS);
                else if (skip > 1)  rep = mk_rep(E_BIGGAP);
            end
        end else if (phase_end && !bus_reset && last_valid && (|bad_vec)) begin
            rep = mk_rep(E_PORTS);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || bus_reset) begin
            exp_id     <= '0;
            pkt_id     <= '0;
            pkt_ports  <= '0;
            last_ports <= '0;
            last_valid <= 1'b0;
            in_pkt     <= 1'b0;
            gap_seen   <= 1'b0;
        end else begin
            if (dat_stb && !in_pkt) begin
                in_pkt    <= 1'b1;
                pkt_id    <= id_in;
                pkt_ports <= ports_in;
                if (id_in >= exp_id) exp_id   <= id_in + 1'b1;
                if (id_in > exp_id)  gap_seen <= 1'b1;
            end
            if (pkt_end) begin
                in_pkt     <= 1'b0;
                last_ports <= pkt_ports;
                last_valid <= in_pkt;
            end
        end
    end

    // R11: bus reset restarts the expected ID at zero
    a_r11_exp_restart: assert property (@(posedge clk) disable iff (rst)
        bus_reset |=> (exp_id == '0) && !in_pkt && !gap_seen);

    // R4: a first quadlet at or above the expected ID moves the expectation past it
    a_r4_exp_step: assert property (@(posedge clk) disable iff (rst)
        (dat_stb && !in_pkt && !bus_reset && id_in >= exp_id)
        |=> exp_id == ID_W'($past(id_in) + 1'b1));

endmodule

// File: rtl/sid_err_latch.sv
module sid_err_latch
    import sidchk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  err_rep_t  pair_rep,
    input  err_rep_t  order_rep,
    input  logic      clr_wr,
    input  logic      clr_data,
    input  logic      irq_en,
    output err_code_e err_code,
    output logic      err_flag,
    output logic      irq
);
    err_rep_t sel;
    logic     clr;
    logic     armed;

    assign sel   = pair_rep.hit ? pair_rep : order_rep;
    assign clr   = clr_wr && clr_data;
    assign armed = !err_flag || clr;
    assign irq   = err_flag && irq_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            err_code <= E_NONE;
            err_flag <= 1'b0;
        end else if (armed && sel.hit) begin
            err_code <= sel.code;
            err_flag <= 1'b1;
        end else if (clr) begin
            err_code <= E_NONE;
            err_flag <= 1'b0;
        end
    end

    // R8: a set flag always carries a non-zero code
    a_r8_flag_has_code: assert property (@(posedge clk) disable iff (rst)
        err_flag |-> err_code != E_NONE);

    // R8: without a clear, the first code is held
    a_r8_first_held: assert property (@(posedge clk) disable iff (rst)
        (err_flag && !clr) |=> err_flag && $stable(err_code));

    // R9: a clear with no new error empties flag and code
    a_r9_clear_empties: assert property (@(posedge clk) disable iff (rst)
        (clr && !sel.hit) |=> !err_flag && err_code == E_NONE);

    // R10: no interrupt without the flag
    a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
        !err_flag |-> !irq);

endmodule

// File: rtl/sid_seq_checker.sv
module sid_seq_checker
    import sidchk_pkg::*;
#(
    parameter int QW    = 32,
    parameter int ID_W  = 6,
    parameter int NPORT = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_reset,
    input  logic          q_valid,
    input  logic [QW-1:0] q_data,
    input  logic          q_eop,
    input  logic          phase_end,
    input  logic          clr_wr,
    input  logic          clr_data,
    input  logic          irq_en,
    output logic [2:0]    err_code,
    output logic          err_flag,
    output logic          irq
);
    localparam int ID_MSB   = QW - 3;
    localparam int PORT_MSB = 7;

    logic      dat_stb;
    logic      pkt_end;
    err_rep_t  pair_rep;
    err_rep_t  order_rep;
    err_code_e code_q;

    sid_pair_track #(.QW(QW)) u_pair (
        .clk       (clk),
        .rst       (rst),
        .bus_reset (bus_reset),
        .q_valid   (q_valid),
        .q_data    (q_data),
        .q_eop     (q_eop),
        .phase_end (phase_end),
        .dat_stb   (dat_stb),
        .pkt_end   (pkt_end),
        .rep       (pair_rep)
    );

    sid_id_order #(.ID_W(ID_W), .NPORT(NPORT)) u_order (
        .clk       (clk),
        .rst       (rst),
        .bus_reset (bus_reset),
        .dat_stb   (dat_stb),
        .id_in     (q_data[ID_MSB -: ID_W]),
        .ports_in  (q_data[PORT_MSB -: 2*NPORT]),
        .pkt_end   (pkt_end),
        .phase_end (phase_end),
        .rep       (order_rep)
    );

    sid_err_latch u_latch (
        .clk       (clk),
        .rst       (rst),
        .pair_rep  (pair_rep),
        .order_rep (order_rep),
        .clr_wr    (clr_wr),
        .clr_data  (clr_data),
        .irq_en    (irq_en),
        .err_code  (code_q),
        .err_flag  (err_flag),
        .irq       (irq)
    );

    assign err_code = code_q;

endmodule

// File: tb/sid_seq_checker_tb_top.sv
module sid_seq_checker_tb_top;
    logic        clk = 1'b0;
    logic        rst, bus_reset, q_valid, q_eop, phase_end, clr_wr, clr_data, irq_en;
    logic [31:0] q_data;
    logic [2:0]  err_code;
    logic        err_flag, irq;
    int          total = 0;
    int          bad   = 0;

    always #5 clk = ~clk;

    sid_seq_checker dut_i (
        .clk(clk), .rst(rst), .bus_reset(bus_reset), .q_valid(q_valid),
        .q_data(q_data), .q_eop(q_eop), .phase_end(phase_end),
        .clr_wr(clr_wr), .clr_data(clr_data), .irq_en(irq_en),
        .err_code(err_code), .err_flag(err_flag), .irq(irq)
    );

    function automatic logic [31:0] mk(input logic [5:0] id, input logic [5:0] ports);
        return {2'b10, id, 16'h0000, ports, 2'b00};
    endfunction

    task automatic chk(input string req, input int act, input int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic qd(input logic [31:0] d, input logic e);
        q_valid = 1'b1; q_data = d; q_eop = e;
        @(negedge clk);
        q_valid = 1'b0; q_eop = 1'b0;
    endtask

    task automatic pair(input logic [31:0] d, input logic e);
        qd(d, 1'b0);
        qd(~d, e);
    endtask

    task automatic pkt(input logic [5:0] id, input logic [5:0] ports);
        pair(mk(id, ports), 1'b1);
    endtask

    task automatic breset();
        bus_reset = 1'b1; @(negedge clk); bus_reset = 1'b0;
    endtask

    task automatic pend();
        phase_end = 1'b1; @(negedge clk); phase_end = 1'b0;
    endtask

    task automatic sw_clear();
        clr_wr = 1'b1; clr_data = 1'b1; @(negedge clk); clr_wr = 1'b0; clr_data = 1'b0;
    endtask

    task automatic fresh();
        sw_clear();
        breset();
    endtask

    task automatic t_reset();
        chk("R1 code", err_code, 0);
        chk("R1 flag", err_flag, 0);
        chk("R1 irq", irq, 0);
    endtask

    task automatic t_good();
        fresh();
        pkt(6'd0, 6'b10_00_00);
        pkt(6'd1, 6'b10_11_00);
        pair(mk(6'd2, 6'b11_11_00), 1'b0);
        pair({2'b10, 6'd2, 24'h5a5a5a}, 1'b1);
        pend();
        chk("R4 R6 R7 clean stream code", err_code, 0);
        chk("R7 clean stream flag", err_flag, 0);
    endtask

    task automatic t_inv();
        fresh();
        qd(mk(6'd0, 6'd0), 1'b0);
        qd(~mk(6'd0, 6'd0) ^ 32'h0000_0100, 1'b1);
        chk("R2 bad inverse code", err_code, 7);
        chk("R8 flag set", err_flag, 1);
        irq_en = 1'b1; #1;
        chk("R10 irq on", irq, 1);
        irq_en = 1'b0; #1;
        chk("R10 irq masked", irq, 0);
    endtask

    task automatic t_phase();
        fresh();
        qd(mk(6'd0, 6'd0), 1'b1);
        chk("R3 eop in data slot", err_code, 3);
        fresh();
        qd(mk(6'd0, 6'd0), 1'b0);
        qd(mk(6'd0, 6'd0), 1'b0);
        chk("R3 data in check slot", err_code, 3);
        fresh();
        qd(mk(6'd0, 6'd0), 1'b0);
        pend();
        chk("R3 phase end with check owed", err_code, 3);
        fresh();
        qd(32'h4000_0000, 1'b0);
        chk("R3 bad tag in data slot", err_code, 3);
    endtask

    task automatic t_idmis();
        fresh();
        pkt(6'd0, 6'd0);
        pkt(6'd0, 6'd0);
        chk("R4 repeated id", err_code, 2);
    endtask

    task automatic t_gaps();
        fresh();
        pkt(6'd0, 6'd0);
        pkt(6'd2, 6'd0);
        chk("R5 single skip tolerated", err_flag, 0);
        pkt(6'd4, 6'd0);
        chk("R5 second skip", err_code, 4);
        fresh();
        pkt(6'd0, 6'd0);
        pkt(6'd3, 6'd0);
        chk("R5 wide skip", err_code, 5);
    endtask

    task automatic t_inpkt();
        fresh();
        pair(mk(6'd0, 6'd0), 1'b0);
        pair(mk(6'd1, 6'd0), 1'b1);
        chk("R6 id change in packet", err_code, 6);
    endtask

    task automatic t_ports();
        fresh();
        pkt(6'd0, 6'b11_10_00);
        chk("R7 no error before phase end", err_flag, 0);
        pend();
        chk("R7 parent port in last", err_code, 1);
        fresh();
        pkt(6'd0, 6'b00_01_11);
        pend();
        chk("R7 port value 01 in last", err_code, 1);
    endtask

    task automatic t_first_and_clear();
        fresh();
        pkt(6'd0, 6'd0);
        pkt(6'd0, 6'd0);
        qd(mk(6'd1, 6'd0), 1'b0);
        qd(32'h0, 1'b1);
        chk("R8 first code kept", err_code, 2);
        clr_wr = 1'b1; clr_data = 1'b0; @(negedge clk); clr_wr = 1'b0;
        chk("R9 write of 0 ignored", err_flag, 1);
        chk("R9 write of 0 keeps code", err_code, 2);
        qd(mk(6'd2, 6'd0), 1'b0);
        clr_wr = 1'b1; clr_data = 1'b1;
        qd(32'h0, 1'b1);
        clr_wr = 1'b0; clr_data = 1'b0;
        chk("R9 error in clear cycle latched", err_code, 7);
        sw_clear();
        chk("R9 clear flag", err_flag, 0);
        chk("R9 clear code", err_code, 0);
    endtask

    task automatic t_busreset();
        fresh();
        qd(mk(6'd0, 6'd0), 1'b1);
        breset();
        chk("R11 code kept over bus reset", err_code, 3);
        chk("R11 flag kept over bus reset", err_flag, 1);
        sw_clear();
        pkt(6'd0, 6'd0);
        qd(mk(6'd1, 6'd0), 1'b0);
        bus_reset = 1'b1;
        qd(mk(6'd7, 6'd0), 1'b0);
        bus_reset = 1'b0;
        pkt(6'd0, 6'd0);
        chk("R11 sequence restarted", err_flag, 0);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #2000000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst = 1'b1; bus_reset = 1'b0; q_valid = 1'b0; q_eop = 1'b0; q_data = '0;
        phase_end = 1'b0; clr_wr = 1'b0; clr_data = 1'b0; irq_en = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_good();
        t_inv();
        t_phase();
        t_idmis();
        t_gaps();
        t_inpkt();
        t_ports();
        t_first_and_clear();
        t_busreset();
        finish_run();
    end
endmodule